// File: doc/BRIEF.md
# HDB3 Receive Line Alarm Monitor

This block watches the two recovered receive rails of an HDB3 line, one sample per bit period, and raises three alarms. A coding-violation pulse marks every bit at which the mark pattern breaks the alternate-mark rule in a way that a legal zero-substitution sequence cannot explain. A loss-of-signal alarm, active low, falls once the line has stayed at zero for a fixed run of bit periods and rises again at the next mark. A line-quality flag reports, once per measurement interval, whether the number of violations in that interval was above the count that matches an error rate of one in a million.

The interval length and the violation threshold are parameters. By default they follow the selected line rate: ten seconds of bits at 34.368 Mbit/s, or forty seconds at 8.448 Mbit/s, with the threshold derived as the interval length divided by one million. Simulation overrides both with small values. A bypass input marks raw-rail operation, in which the violation and quality outputs carry no meaning and are held low.

Top module: `line_alarm_mon`

## Requirements
- R1: Each sample is decoded as zero (both rails low), positive mark (`rx_pos`=1, `rx_neg`=0) or negative mark (`rx_pos`=0, `rx_neg`=1); marks that alternate in polarity give no violation, and `cv_pulse` shows the result for a sample during the cycle after the edge that takes it.
- R2: A mark with the same polarity as the previous mark and fewer than two zeros in between is a violation and gives a one-cycle `cv_pulse`.
- R3: A same-polarity mark preceded by at least two zeros is a legal substitution and gives no pulse when it is the first such mark since reset or its polarity differs from the previous same-polarity mark.
- R4: A same-polarity mark preceded by at least two zeros whose polarity equals that of the previous same-polarity mark gives a `cv_pulse`.
- R5: A sample with both rails high gives a `cv_pulse` and leaves the stored mark polarity unchanged.
- R6: `los_n` goes low at the edge that takes the LOS_RUN-th consecutive zero sample (default 24), stays high before it, and stays low while zeros continue.
- R7: Any mark sample sets `los_n` high at the edge that takes it and restarts the zero count.
- R8: `lq_bad` changes only at the edge that takes the last sample of each interval of INTERVAL_LEN samples counted from reset release; it is then set high when the violations in that interval exceed ERR_THRESH and low otherwise.
- R9: The violation count saturates above the threshold and restarts at zero in every interval.
- R10: While `bypass` is high, `cv_pulse` and `lq_bad` are held low after each edge and violations are not counted; detection resumes as soon as `bypass` falls.
- R11: While `rst` is high, `cv_pulse` is 0, `los_n` is 1 and `lq_bad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock, one sample per edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_pos | input | 1 | Positive receive rail |
| rx_neg | input | 1 | Negative receive rail |
| bypass | input | 1 | Raw-rail mode; forces violation and quality outputs low |
| cv_pulse | output | 1 | Coding-violation pulse, one bit period wide |
| los_n | output | 1 | Loss of signal, active low |
| lq_bad | output | 1 | Line-quality failure flag for the last interval |

## Verification
Every output is one register away from the rails: `cv_pulse` answers for a sample at the edge that takes it, `los_n` falls at the edge that takes the LOS_RUN-th zero, and `lq_bad` moves only at the edge that takes the last sample of an interval. The bench drives each sample just after an edge and reads the outputs one nanosecond after the next edge, so each check looks at exactly the cycle that answers for the sample just sent. It counts samples from reset release to know where each interval ends, aligns every quality test to an interval start, and works out the expected flag from the number of errors it placed outside the bypass window.

// File: rtl/hdb3_mon_pkg.sv
package hdb3_mon_pkg;

    // Rail pair decoded as one symbol: {neg, pos}
    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_POS  = 2'b01,
        SYM_NEG  = 2'b10,
        SYM_BOTH = 2'b11
    } sym_e;

    // Tracking state of the violation detector
    typedef struct packed {
        logic       seen;   // a mark has arrived since reset
        logic       pol;    // polarity of last mark, 1 = negative
        logic       vseen;  // a same-polarity mark has arrived since reset
        logic       vpol;   // polarity of last same-polarity mark
        logic [1:0] zrun;   // zeros since last mark, saturating at 3
    } cv_state_t;

    localparam int unsigned FAST_RATE_BPS = 34_368_000;
    localparam int unsigned SLOW_RATE_BPS = 8_448_000;
    localparam int unsigned FAST_INTERVAL = FAST_RATE_BPS * 10;
    localparam int unsigned SLOW_INTERVAL = SLOW_RATE_BPS * 40;

    function automatic sym_e sym_of(input logic p, input logic n);
        return sym_e'({n, p});
    endfunction

    // Violations allowed for a 1e-6 error rate over len bits
    function automatic int unsigned thresh_of(input int unsigned len);
        return len / 1_000_000;
    endfunction

endpackage

// File: rtl/cv_detect.sv
module cv_detect
    import hdb3_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sym_e sym,
    input  logic bypass,
    output logic err_now,
    output logic cv_pulse
);

    cv_state_t st_q, st_d;
    logic      err;
    logic      pol;

    always_comb begin
        st_d = st_q;
        err  = 1'b0;
        pol  = (sym == SYM_NEG);
        case (sym)
            SYM_ZERO: begin
                if (st_q.zrun != 2'd3) st_d.zrun = st_q.zrun + 2'd1;
            end
            SYM_BOTH: begin
                err       = 1'b1;
                st_d.zrun = 2'd0;
            end
            default: begin
                if (st_q.seen && (pol == st_q.pol)) begin
                    if (st_q.zrun < 2'd2)
                        err = 1'b1;
                    else if (st_q.vseen && (st_q.vpol == pol))
                        err = 1'b1;
                    st_d.vseen = 1'b1;
                    st_d.vpol  = pol;
                end
                st_d.seen = 1'b1;
                st_d.pol  = pol;
                st_d.zrun = 2'd0;
            end
        endcase
    end

    assign err_now = err & ~bypass;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            cv_pulse <= 1'b0;
        end else begin
            st_q     <= st_d;
            cv_pulse <= err_now;
        end
    end

    // R5
    both_rail_cv_chk: assert property (@(posedge clk) disable iff (rst)
        (sym == SYM_BOTH && !bypass) |=> cv_pulse);

    // R10
    bypass_cv_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |=> !cv_pulse);

    // R1
    alternate_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.seen && (sym == SYM_POS || sym == SYM_NEG) && (pol != st_q.pol))
        |=> !cv_pulse);

endmodule

// File: rtl/zero_run.sv
module zero_run #(
    parameter int unsigned RUN_LEN = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic is_zero,
    output logic los_n
);

    localparam int unsigned CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            los_n <= 1'b1;
        end else if (!is_zero) begin
            cnt   <= '0;
            los_n <= 1'b1;
        end else begin
            if (cnt != CW'(RUN_LEN)) cnt <= cnt + 1'b1;
            if (cnt >= CW'(RUN_LEN - 1)) los_n <= 1'b0;
        end
    end

    // R7
    mark_clears_los_chk: assert property (@(posedge clk) disable iff (rst)
        !is_zero |=> los_n);

    // R6
    los_needs_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(los_n) |-> $past(is_zero));

endmodule

// File: rtl/quality_timer.sv
module quality_timer #(
    parameter int unsigned INTERVAL_LEN = 64,
    parameter int unsigned ERR_THRESH   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic err_now,
    input  logic bypass,
    output logic lq_bad
);

    localparam int unsigned TW  = $clog2(INTERVAL_LEN + 1);
    localparam int unsigned SAT = ERR_THRESH + 1;
    localparam int unsigned VW  = $clog2(SAT + 1);

    logic [TW-1:0] tcnt;
    logic [VW-1:0] vcnt, vnext;
    logic          last_bit;

    assign last_bit = (tcnt == TW'(INTERVAL_LEN - 1));
    assign vnext    = (err_now && vcnt != VW'(SAT)) ? vcnt + 1'b1 : vcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt   <= '0;
            vcnt   <= '0;
            lq_bad <= 1'b0;
        end else begin
            if (last_bit) begin
                tcnt   <= '0;
                vcnt   <= '0;
                lq_bad <= !bypass && (vnext > VW'(ERR_THRESH));
            end else begin
                tcnt <= tcnt + 1'b1;
                vcnt <= vnext;
                if (bypass) lq_bad <= 1'b0;
            end
        end
    end

    // R9
    count_sat_chk: assert property (@(posedge clk) disable iff (rst)
        vcnt <= VW'(SAT));

    // R8
    lq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!last_bit && !bypass) |=> $stable(lq_bad));

    // R10
    bypass_lq_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |=> !lq_bad);

endmodule

// File: rtl/line_alarm_mon.sv
module line_alarm_mon
    import hdb3_mon_pkg::*;
#(
    parameter bit          SLOW_RATE    = 1'b0,
    parameter int unsigned LOS_RUN      = 24,
    parameter int unsigned INTERVAL_LEN = SLOW_RATE ? SLOW_INTERVAL : FAST_INTERVAL,
    parameter int unsigned ERR_THRESH   = thresh_of(INTERVAL_LEN)
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic bypass,
    output logic cv_pulse,
    output logic los_n,
    output logic lq_bad
);

    sym_e sym;
    logic err_now;

    assign sym = sym_of(rx_pos, rx_neg);

    cv_detect u_cv (
        .clk      (clk),
        .rst      (rst),
        .sym      (sym),
        .bypass   (bypass),
        .err_now  (err_now),
        .cv_pulse (cv_pulse)
    );

    zero_run #(.RUN_LEN(LOS_RUN)) u_zr (
        .clk     (clk),
        .rst     (rst),
        .is_zero (sym == SYM_ZERO),
        .los_n   (los_n)
    );

    quality_timer #(
        .INTERVAL_LEN (INTERVAL_LEN),
        .ERR_THRESH   (ERR_THRESH)
    ) u_qt (
        .clk     (clk),
        .rst     (rst),
        .err_now (err_now),
        .bypass  (bypass),
        .lq_bad  (lq_bad)
    );

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!cv_pulse && los_n && !lq_bad));

endmodule

// File: tb/line_alarm_mon_tb_top.sv
`timescale 1ns/100ps
module line_alarm_mon_tb_top;

    localparam int unsigned L   = 64;
    localparam int unsigned THR = 3;
    localparam int unsigned RUN = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_pos = 1'b0, rx_neg = 1'b0, bypass = 1'b0;
    logic cv_pulse, los_n, lq_bad;

    int total = 0;
    int bad = 0;
    int scount = 0;
    logic lastneg = 1'b1;
    logic lq_prev = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    line_alarm_mon #(
        .LOS_RUN(RUN), .INTERVAL_LEN(L), .ERR_THRESH(THR)
    ) dut_i (
        .clk(clk), .rst(rst), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .bypass(bypass), .cv_pulse(cv_pulse), .los_n(los_n), .lq_bad(lq_bad)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b (sample %0d)", req, act, exp, scount);
        end
    endtask

    task automatic send(input logic p, input logic n);
        rx_pos = p;
        rx_neg = n;
        if (p ^ n) lastneg = n;
        @(posedge clk);
        #1;
        scount++;
    endtask

    task automatic sc(input logic p, input logic n, input logic exp, input string req);
        send(p, n);
        chk(req, cv_pulse, exp);
    endtask

    task automatic ami();
        send(lastneg, !lastneg);
    endtask

    task automatic zeros(input int k);
        for (int i = 0; i < k; i++) send(1'b0, 1'b0);
    endtask

    // Quality interval: nerr both-rail errors first, bypass over first nbyp samples
    task automatic run_interval(input int nerr, input int nbyp, input bit midchk);
        int   counted;
        logic exp;
        while ((scount % L) != 0) ami();
        counted = (nerr > nbyp) ? nerr - nbyp : 0;
        exp = (counted > THR);
        for (int i = 0; i < L; i++) begin
            bypass = (i < nbyp);
            if (i < nerr) send(1'b1, 1'b1);
            else ami();
            if (i == 0 && nbyp > 0) chk("R10 lq forced low", lq_bad, 1'b0);
            if (i == L/2 && nbyp == 0 && midchk) chk("R8 lq held mid-interval", lq_bad, lq_prev);
        end
        bypass = 1'b0;
        chk((nerr >= L) ? "R9 saturated interval" : "R8 interval end", lq_bad, exp);
        lq_prev = exp;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        if (!done) begin end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got running expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11 cv reset", cv_pulse, 1'b0);
        chk("R11 los reset", los_n, 1'b1);
        chk("R11 lq reset", lq_bad, 1'b0);
        rst = 1'b0;
        scount = 0;

        // R1 alternating marks
        sc(1,0,0,"R1"); sc(0,1,0,"R1"); sc(1,0,0,"R1"); sc(0,1,0,"R1");
        // R3 first substitution 000V, then 000V opposite, then B00V
        zeros(3); sc(0,1,0,"R3 first 000V");
        sc(1,0,0,"R1");
        zeros(3); sc(1,0,0,"R3 000V alternating");
        sc(0,1,0,"R1"); sc(1,0,0,"R1");
        sc(0,1,0,"R1"); zeros(2); sc(0,1,0,"R3 B00V");
        // R4 repeated violation polarity
        zeros(3); sc(0,1,1,"R4");
        // R2 close same-polarity marks
        sc(1,0,0,"R1"); send(0,0); sc(1,0,1,"R2 one zero"); sc(1,0,1,"R2 back to back");
        // R5 both rails
        sc(0,1,0,"R1"); sc(1,1,1,"R5"); sc(1,0,0,"R5 polarity kept");
        sc(1,1,1,"R5"); sc(1,1,1,"R5 repeated");
        // R10 bypass suppresses pulses
        bypass = 1'b1;
        sc(1,1,0,"R10 both rails"); sc(0,1,0,"R10"); sc(0,1,0,"R10 same polarity");
        bypass = 1'b0;
        sc(0,1,1,"R10 released");

        // R6 / R7 loss of signal
        send(1,0);
        chk("R7 mark", los_n, 1'b1);
        zeros(RUN - 1);
        chk("R6 before limit", los_n, 1'b1);
        zeros(1);
        chk("R6 at limit", los_n, 1'b0);
        zeros(5);
        chk("R6 held", los_n, 1'b0);
        send(0,1);
        chk("R7 recovery", los_n, 1'b1);
        zeros(RUN - 1);
        send(1,0);
        chk("R7 mark before limit", los_n, 1'b1);
        zeros(RUN - 1);
        chk("R7 count restarted", los_n, 1'b1);
        send(0,1);

        // R8 / R9 / R10 line quality
        run_interval(THR, 0, 1'b0);
        run_interval(THR + 1, 0, 1'b1);
        run_interval(0, 0, 1'b1);
        run_interval(L, 0, 1'b1);
        run_interval(0, 0, 1'b1);
        run_interval(THR + 2, 0, 1'b1);
        run_interval(L, L, 1'b0);
        run_interval(40, 38, 1'b0);
        run_interval(36, 32, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule